// File: doc/BRIEF.md
# SGRAM Command Sequencer

This block sits between a memory controller's scheduler and the command pins of a two-bank synchronous graphics RAM. The scheduler offers one request at a time (activate, read, read with auto-precharge, write, precharge), with a bank, a row or column, and write data. The sequencer checks the request against the open state of the target bank and its own timing counters. It then drives the registered strobe, bank-select and address pins for one cycle, followed by NOP cycles.

During a burst the sequencer advances the column each cycle, wrapping at the end of the page. It drives write data beginning in the command cycle. It captures read data once the configured CAS latency has elapsed. Full-page bursts run until the next issued command. The sequencer deasserts ready while an activate-to-write delay, a finite burst or an auto-precharge lockout is pending.

Top module: `sgram_cmd_seq`

## Requirements
- R1: After reset and in idle cycles the strobes are NOP (ras_n_o, cas_n_o, we_n_o all 1), dsf_o is 0, dq_oe_o, err_o and rd_valid_o are 0, and req_ready_o is 1.
- R2: A request is accepted in a cycle where req_valid_i and req_ready_o are both high. Its pins appear in the following cycle. Activate (req_op_i=1) drives ras_n=0, cas_n=1, we_n=1, bs_o=bank, addr_o=row. Precharge (req_op_i=5) drives ras_n=0, cas_n=1, we_n=0, addr_o=0.
- R3: Write (req_op_i=4) drives ras_n=1, cas_n=0, we_n=0, dsf_o=0, addr_o[7:0]=column, addr_o[8]=0 and addr_o[10:9]=0.
- R4: Read (req_op_i=2) drives ras_n=1, cas_n=0, we_n=1, addr_o[7:0]=column and addr_o[8]=0. Read with auto-precharge (req_op_i=3) is identical except that addr_o[8]=1 when the burst is finite.
- R5: After an activate is accepted, req_ready_o stays low for T_RCD-1 cycles. As a result, no write reaches the pins earlier than T_RCD cycles after the activate.
- R6: Write data presented on wr_data_i k cycles after acceptance appears on dq_o, with dq_oe_o high, k+1 cycles after acceptance. Beat 0 therefore coincides with the write command. dq_oe_o falls after the last beat.
- R7: The value on dq_i during cycle P+CAS_LAT+k is presented on rd_data_o with rd_valid_o high one cycle later, for each beat k of a read issued in cycle P.
- R8: A read or write to a closed bank is not issued. The pins stay NOP, err_o pulses for one cycle, and no data beat follows.
- R9: A finite burst holds req_ready_o low for BURST_LEN-1 cycles after its command cycle, so the next command can follow the last beat directly.
- R10: A read with auto-precharge on a finite burst holds req_ready_o low until the next command can reach the pins no earlier than T_RP+BURST_LEN cycles after it. It also closes the bank.
- R11: With a full-page burst (BURST_LEN = 2^COL_W), auto-precharge is ignored. addr_o[8] is 0, there is no lockout, and the bank stays open. The burst runs until another command is issued.
- R12: burst_col_o gives the column of the current beat. It starts at the requested column and increments by one per beat, wrapping from 255 to 0.
- R13: Open state is kept per bank. A precharge closes only the bank it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_op_i | input | 3 | Request code: 1 activate, 2 read, 3 read with auto-precharge, 4 write, 5 precharge |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ADDR_W | Row for activate |
| req_col_i | input | COL_W | Start column for read or write |
| wr_data_i | input | DQ_W | Write data, one word per cycle from acceptance |
| dq_i | input | DQ_W | Data returned by the memory |
| req_ready_o | output | 1 | Request can be accepted |
| err_o | output | 1 | Pulse on a read or write to a closed bank |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dsf_o | output | 1 | Special-function select, held low |
| bs_o | output | BANK_W | Bank select |
| addr_o | output | ADDR_W | Row, or column plus auto-precharge bit |
| dq_o | output | DQ_W | Write data to pins |
| dq_oe_o | output | 1 | Write data drive enable |
| burst_col_o | output | COL_W | Column of the current beat |
| rd_data_o | output | DQ_W | Captured read word |
| rd_valid_o | output | 1 | rd_data_o holds a new word |

## Verification
The bench builds two instances. The first uses a 4-beat burst, CAS latency 2, T_RCD 3 and T_RP 2. These short windows let every lockout cycle, every write beat and every read capture slot be checked at its exact cycle. The second uses a 256-column full-page burst with CAS latency 3. It covers column wrap, the ignored auto-precharge bit, a burst running for 300 cycles, and termination by a new command. Read data on dq_i is a known function of the cycle number, so each captured word can be checked arithmetically.

// File: rtl/sgram_seq_pkg.sv
`timescale 1ns/1ps
package sgram_seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_RDA = 3'd3,
    OP_WR  = 3'd4,
    OP_PRE = 3'd5
  } op_e;
endpackage

// File: rtl/sgram_bank_track.sv
`timescale 1ns/1ps
module sgram_bank_track #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  parameter int T_RCD     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_i,
  input  logic                 close_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic                 rcd_busy_o
);
  localparam int RCD_W = $clog2(T_RCD + 1);

  logic [RCD_W-1:0]     rcd_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] busy_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        rcd_q[b]  <= '0;
      end else if (act_i && hit) begin
        open_o[b] <= 1'b1;
        rcd_q[b]  <= RCD_W'(T_RCD - 1);
      end else begin
        if (close_i && hit) open_o[b] <= 1'b0;
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
      end
    end
    assign busy_vec[b] = (rcd_q[b] != '0);
  end

  assign rcd_busy_o = |busy_vec;
endmodule

// File: rtl/sgram_burst_ctl.sv
`timescale 1ns/1ps
module sgram_burst_ctl #(
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_rd_i,
  input  logic             ap_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  output logic             rd_slot_o,
  output logic             wr_slot_o,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o
);
  localparam bit FULL_PAGE = (BURST_LEN == (1 << COL_W));
  localparam int BEAT_W    = $clog2(BURST_LEN + 1);
  localparam int LOCK_N    = T_RP + BURST_LEN - 1;
  localparam int LOCK_W    = $clog2(LOCK_N + 2);

  logic [BEAT_W-1:0] beats_q;
  logic [LOCK_W-1:0] lock_q;
  logic              fp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_slot_o <= 1'b0;
      wr_slot_o <= 1'b0;
      col_o     <= '0;
      beats_q   <= '0;
      fp_q      <= 1'b0;
    end else if (start_i) begin
      rd_slot_o <= start_rd_i;
      wr_slot_o <= !start_rd_i;
      col_o     <= col_i;
      beats_q   <= FULL_PAGE ? '0 : BEAT_W'(BURST_LEN - 1);
      fp_q      <= FULL_PAGE;
    end else if (stop_i) begin
      rd_slot_o <= 1'b0;
      wr_slot_o <= 1'b0;
      beats_q   <= '0;
      fp_q      <= 1'b0;
    end else if (fp_q) begin
      col_o <= col_o + 1'b1;  // page wrap falls out of the width
    end else if (beats_q != '0) begin
      beats_q <= beats_q - 1'b1;
      col_o   <= col_o + 1'b1;
    end else begin
      rd_slot_o <= 1'b0;
      wr_slot_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lock_q <= '0;
    else if (start_i && ap_i)   lock_q <= LOCK_W'(LOCK_N);
    else if (lock_q != '0)      lock_q <= lock_q - 1'b1;
  end

  assign busy_o = (lock_q != '0) || (beats_q != '0);
endmodule

// File: rtl/sgram_rd_capture.sv
`timescale 1ns/1ps
module sgram_rd_capture #(
  parameter int DQ_W    = 32,
  parameter int CAS_LAT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slot_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic [DQ_W-1:0] rd_data_o,
  output logic            rd_valid_o
);
  logic [CAS_LAT-1:0] pipe_q;

  if (CAS_LAT == 1) begin : g_cl1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= slot_i;
    end
  end else begin : g_cln
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[CAS_LAT-2:0], slot_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= pipe_q[CAS_LAT-1];
      if (pipe_q[CAS_LAT-1]) rd_data_o <= dq_i;
    end
  end
endmodule

// File: rtl/sgram_cmd_seq.sv
`timescale 1ns/1ps
module sgram_cmd_seq #(
  parameter int DQ_W      = 32,
  parameter int ADDR_W    = 11,
  parameter int COL_W     = 8,
  parameter int NUM_BANKS = 2,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ADDR_W-1:0] req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DQ_W-1:0]   wr_data_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              req_ready_o,
  output logic              err_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              dsf_o,
  output logic [BANK_W-1:0] bs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic [COL_W-1:0]  burst_col_o,
  output logic [DQ_W-1:0]   rd_data_o,
  output logic              rd_valid_o
);
  import sgram_seq_pkg::*;

  localparam bit FULL_PAGE = (BURST_LEN == (1 << COL_W));

  op_e                  op;
  logic                 accept, is_rw, is_rd, bank_ok;
  logic                 issue_rw, issue_act, issue_pre, err_d, ap_eff, close_bank;
  logic [NUM_BANKS-1:0] bank_open;
  logic                 rcd_busy, burst_busy, rd_slot;
  logic [ADDR_W-1:0]    rw_addr;

  assign op        = op_e'(req_op_i);
  assign accept    = req_valid_i && req_ready_o;
  assign is_rd     = (op == OP_RD) || (op == OP_RDA);
  assign is_rw     = is_rd || (op == OP_WR);
  assign bank_ok   = bank_open[req_bank_i];
  assign issue_rw  = accept && is_rw && bank_ok;
  assign err_d     = accept && is_rw && !bank_ok;
  assign issue_act = accept && (op == OP_ACT);
  assign issue_pre = accept && (op == OP_PRE);
  assign ap_eff    = (op == OP_RDA) && !FULL_PAGE;
  assign close_bank = issue_pre || (issue_rw && ap_eff);

  always_comb begin
    rw_addr            = '0;
    rw_addr[COL_W-1:0] = req_col_i;
    rw_addr[COL_W]     = ap_eff;
  end

  sgram_bank_track #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_RCD(T_RCD)
  ) u_banks (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(issue_act), .close_i(close_bank),
    .bank_i(req_bank_i), .open_o(bank_open), .rcd_busy_o(rcd_busy)
  );

  sgram_burst_ctl #(
    .COL_W(COL_W), .BURST_LEN(BURST_LEN), .T_RP(T_RP)
  ) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(issue_rw), .start_rd_i(is_rd),
    .ap_i(ap_eff), .stop_i(issue_act || issue_pre), .col_i(req_col_i),
    .rd_slot_o(rd_slot), .wr_slot_o(dq_oe_o), .col_o(burst_col_o),
    .busy_o(burst_busy)
  );

  sgram_rd_capture #(
    .DQ_W(DQ_W), .CAS_LAT(CAS_LAT)
  ) u_rdcap (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(rd_slot), .dq_i(dq_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  assign req_ready_o = !burst_busy && !rcd_busy;
  assign dsf_o       = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      bs_o    <= '0;
      addr_o  <= '0;
      err_o   <= 1'b0;
      dq_o    <= '0;
    end else begin
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      err_o   <= err_d;
      dq_o    <= wr_data_i;  // beat k leaves one cycle after it is offered
      if (issue_act) begin
        ras_n_o <= 1'b0;
        bs_o    <= req_bank_i;
        addr_o  <= req_row_i;
      end else if (issue_pre) begin
        ras_n_o <= 1'b0;
        we_n_o  <= 1'b0;
        bs_o    <= req_bank_i;
        addr_o  <= '0;
      end else if (issue_rw) begin
        cas_n_o <= 1'b0;
        we_n_o  <= is_rd;
        bs_o    <= req_bank_i;
        addr_o  <= rw_addr;
      end
    end
  end
endmodule

// File: rtl/sgram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sgram_cmd_seq_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 11,
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        req_op_i,
  input logic [BANK_W-1:0] req_bank_i,
  input logic              req_ready_o,
  input logic              err_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BANK_W-1:0] bs_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              dq_oe_o,
  input logic [COL_W-1:0]  burst_col_o
);
  import sgram_seq_pkg::*;

  localparam bit FULL_PAGE = (BURST_LEN == (1 << COL_W));

  logic acc;
  assign acc = req_valid_i && req_ready_o;

  p_act_pins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == OP_ACT) |=>
      (!ras_n_o && cas_n_o && we_n_o && bs_o == $past(req_bank_i)));

  p_rcd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((T_RCD > 1) && acc && req_op_i == OP_ACT) |=> !req_ready_o);

  p_wr_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (ras_n_o && !cas_n_o && !we_n_o));

  p_err_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ras_n_o && cas_n_o && we_n_o));

  p_ap_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!FULL_PAGE && acc && req_op_i == OP_RDA) |=> (err_o || !req_ready_o));

  p_ap_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FULL_PAGE && !cas_n_o) |-> !addr_o[COL_W]);

  p_col_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o) && cas_n_o) |->
      (burst_col_o == $past(burst_col_o) + 1'b1));
endmodule

bind sgram_cmd_seq sgram_cmd_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .COL_W(COL_W),
  .BURST_LEN(BURST_LEN), .T_RCD(T_RCD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_op_i(req_op_i), .req_bank_i(req_bank_i), .req_ready_o(req_ready_o),
  .err_o(err_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .bs_o(bs_o), .addr_o(addr_o), .dq_oe_o(dq_oe_o), .burst_col_o(burst_col_o)
);

// File: tb/sgram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sgram_cmd_seq_tb_top;
  import sgram_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_a = 1'b0, valid_b = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic        req_bank = 1'b0;
  logic [10:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] dq_in = '0;

  logic        ready_a, err_a, ras_a, cas_a, we_a, dsf_a, bs_a, oe_a, rdv_a;
  logic [10:0] addr_a;
  logic [31:0] dq_a, rdd_a;
  logic [7:0]  col_a;
  logic        ready_b, err_b, ras_b, cas_b, we_b, dsf_b, bs_b, oe_b, rdv_b;
  logic [10:0] addr_b;
  logic [31:0] dq_b, rdd_b;
  logic [7:0]  col_b;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;
  always @(negedge clk) dq_in = 32'hA500_0000 | 32'(cyc);

  sgram_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid_a), .req_op_i(req_op),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .wr_data_i(wr_data), .dq_i(dq_in), .req_ready_o(ready_a), .err_o(err_a),
    .ras_n_o(ras_a), .cas_n_o(cas_a), .we_n_o(we_a), .dsf_o(dsf_a), .bs_o(bs_a),
    .addr_o(addr_a), .dq_o(dq_a), .dq_oe_o(oe_a), .burst_col_o(col_a),
    .rd_data_o(rdd_a), .rd_valid_o(rdv_a)
  );

  sgram_cmd_seq #(.BURST_LEN(256), .CAS_LAT(3)) dut_fp_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid_b), .req_op_i(req_op),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .wr_data_i(wr_data), .dq_i(dq_in), .req_ready_o(ready_b), .err_o(err_b),
    .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b), .dsf_o(dsf_b), .bs_o(bs_b),
    .addr_o(addr_b), .dq_o(dq_b), .dq_oe_o(oe_b), .burst_col_o(col_b),
    .rd_data_o(rdd_b), .rd_valid_o(rdv_b)
  );

  function automatic logic [31:0] fdq(int n);
    return 32'hA500_0000 | 32'(n);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // leaves the caller at the negedge of the cycle showing the command pins
  task automatic send(input bit to_b, input logic [2:0] op, input logic bk,
                      input logic [10:0] row, input logic [7:0] col);
    while (to_b ? !ready_b : !ready_a) @(negedge clk);
    req_op = op; req_bank = bk; req_row = row; req_col = col;
    if (to_b) valid_b = 1'b1; else valid_a = 1'b1;
    @(negedge clk);
    valid_a = 1'b0; valid_b = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();

    // R1 reset / idle state
    check("R1 pins", 32'({ras_a, cas_a, we_a}), 32'b111);
    check("R1 dsf", 32'(dsf_a), 0);
    check("R1 oe", 32'(oe_a), 0);
    check("R1 ready", 32'(ready_a), 1);
    check("R1 rd_valid", 32'(rdv_a), 0);
    check("R1 err", 32'(err_a), 0);

    // R8 read to a closed bank
    send(0, OP_RD, 1'b0, '0, 8'h05);
    check("R8 err pulse", 32'(err_a), 1);
    check("R8 pins NOP", 32'({ras_a, cas_a, we_a}), 32'b111);
    step();
    check("R8 err one cycle", 32'(err_a), 0);
    repeat (4) step();
    check("R8 no read beat", 32'(rdv_a), 0);

    // R2 activate, R5 tRCD hold-off
    send(0, OP_ACT, 1'b0, 11'h155, '0);
    check("R2 act pins", 32'({ras_a, cas_a, we_a}), 32'b011);
    check("R2 act bank", 32'(bs_a), 0);
    check("R2 act row", 32'(addr_a), 32'h155);
    check("R5 ready low +1", 32'(ready_a), 0);
    step();
    check("R5 ready low +2", 32'(ready_a), 0);
    step();
    check("R5 ready back", 32'(ready_a), 1);

    // R3 write, R6 data beats, R9 burst ready, R12 column
    wr_data = 32'hC0DE_0000;
    send(0, OP_WR, 1'b0, '0, 8'h10);
    check("R3 wr pins", 32'({ras_a, cas_a, we_a}), 32'b100);
    check("R3 wr addr", 32'(addr_a), 32'h010);
    check("R3 dsf", 32'(dsf_a), 0);
    check("R6 oe beat0", 32'(oe_a), 1);
    check("R6 data beat0", dq_a, 32'hC0DE_0000);
    check("R12 col beat0", 32'(col_a), 32'h10);
    check("R9 ready beat0", 32'(ready_a), 0);
    for (int k = 1; k < 4; k++) begin
      wr_data = 32'hC0DE_0000 + 32'(k);
      step();
      check("R6 oe beat", 32'(oe_a), 1);
      check("R6 data beat", dq_a, 32'hC0DE_0000 + 32'(k));
      check("R12 col beat", 32'(col_a), 32'h10 + 32'(k));
      check("R9 ready in burst", 32'(ready_a), (k == 3) ? 1 : 0);
    end
    step();
    check("R6 oe released", 32'(oe_a), 0);

    // R4 read, R7 capture at CAS latency 2, R12 wrap
    send(0, OP_RD, 1'b0, '0, 8'hFE);
    p = cyc;
    check("R4 rd pins", 32'({ras_a, cas_a, we_a}), 32'b101);
    check("R4 rd addr", 32'(addr_a), 32'h0FE);
    check("R12 col start", 32'(col_a), 32'hFE);
    step();
    check("R12 col 255", 32'(col_a), 32'hFF);
    step();
    check("R12 col wrap", 32'(col_a), 32'h00);
    check("R7 not yet valid", 32'(rdv_a), 0);
    for (int k = 0; k < 4; k++) begin
      step();
      check("R7 rd valid", 32'(rdv_a), 1);
      check("R7 rd data", rdd_a, fdq(p + 2 + k));
    end
    step();
    check("R7 rd valid ends", 32'(rdv_a), 0);

    // R4 auto-precharge bit, R10 lockout and bank close
    send(0, OP_RDA, 1'b0, '0, 8'h20);
    check("R4 rda pins", 32'({ras_a, cas_a, we_a}), 32'b101);
    check("R4 rda addr", 32'(addr_a), 32'h120);
    repeat (4) step();
    check("R10 lockout last", 32'(ready_a), 0);
    step();
    check("R10 lockout end", 32'(ready_a), 1);
    send(0, OP_RD, 1'b0, '0, 8'h00);
    check("R10 bank closed", 32'(err_a), 1);

    // R13 per-bank state
    send(0, OP_ACT, 1'b0, 11'h011, '0);
    send(0, OP_ACT, 1'b1, 11'h022, '0);
    check("R13 act bank1", 32'(bs_a), 1);
    send(0, OP_PRE, 1'b1, '0, '0);
    check("R2 pre pins", 32'({ras_a, cas_a, we_a}), 32'b010);
    check("R2 pre addr", 32'(addr_a), 0);
    check("R13 pre bank", 32'(bs_a), 1);
    send(0, OP_RD, 1'b0, '0, 8'h30);
    check("R13 bank0 open", 32'(err_a), 0);
    check("R13 bank0 read", 32'({ras_a, cas_a, we_a}), 32'b101);
    send(0, OP_WR, 1'b1, '0, 8'h30);
    check("R13 bank1 closed", 32'(err_a), 1);
    check("R13 no write pins", 32'({ras_a, cas_a, we_a}), 32'b111);

    // full-page instance: R11, R12, R7 at CAS latency 3
    send(1, OP_ACT, 1'b0, 11'h2AA, '0);
    check("R2 fp act row", 32'(addr_b), 32'h2AA);
    send(1, OP_RDA, 1'b0, '0, 8'hFD);
    p = cyc;
    check("R11 fp rda pins", 32'({ras_b, cas_b, we_b}), 32'b101);
    check("R11 ap ignored", 32'(addr_b), 32'h0FD);
    check("R11 no lockout", 32'(ready_b), 1);
    step(); step(); step();
    check("R12 fp wrap", 32'(col_b), 32'h00);
    check("R7 cl3 not yet", 32'(rdv_b), 0);
    step();
    check("R7 cl3 valid", 32'(rdv_b), 1);
    check("R7 cl3 data", rdd_b, fdq(p + 3));
    while (cyc < p + 300) step();
    check("R11 burst runs", 32'(rdv_b), 1);
    check("R11 burst data", rdd_b, fdq(p + 299));
    check("R12 fp col", 32'(col_b), 32'h29);
    check("R6 fp no drive", 32'(oe_b), 0);
    send(1, OP_RD, 1'b0, '0, 8'h40);
    check("R11 bank stays open", 32'(err_b), 0);
    check("R11 new read pins", 32'({ras_b, cas_b, we_b}), 32'b101);
    check("R12 restart col", 32'(col_b), 32'h40);
    send(1, OP_PRE, 1'b0, '0, '0);
    check("R2 fp pre pins", 32'({ras_b, cas_b, we_b}), 32'b010);
    repeat (3) step();
    check("R11 last beat", 32'(rdv_b), 1);
    step();
    check("R11 terminated", 32'(rdv_b), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule